// File: doc/BRIEF.md
# CPU Address Decoding Window Unit

This block holds a bank of software-programmed windows that steer CPU physical addresses toward device targets. Each window carries a 36-bit base address and a size with 64 KB granularity. It also carries a 4-bit target code and an 8-bit attribute that name the device behind the window. Software programs the windows through a 32-bit register port. The lookup port takes a 36-bit CPU address. In the same cycle it reports whether a window claims the address, which window that is, its target and attribute, and the address to forward.

Only the lowest-numbered windows, below a parameterised remappable count, carry translation registers. An address that falls in one of these windows is moved to that window's remap base. The remaining windows pass the address through unchanged and hold only a control and a base register. Because of this, the register map is irregular. Remappable windows use a 16-byte stride. A 16-byte reserved hole follows them, and the remaining windows use an 8-byte stride.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every register reads zero and no lookup address hits.
- R2: The control register (window offset +0x0) holds enable in bit 0, target in bits 7:4, attribute in bits 15:8 and size field in bits 31:16; bits 3:1 read back zero.
- R3: The base register (window offset +0x4) holds base address bits 31:16 in bits 31:16 and base bits 35:32 in bits 3:0; all other bits read back zero.
- R4: A window with index below NUM_REMAP has remap-low at +0x8, whose bits 31:16 give translated address bits 31:16, and remap-high at +0xC, whose bits 3:0 give translated bits 35:32; other bits read zero.
- R5: Window i below NUM_REMAP sits at byte offset i*16. Offsets NUM_REMAP*16 to NUM_REMAP*16+15 are a reserved hole that reads zero and ignores writes. Window i at or above NUM_REMAP sits at NUM_REMAP*16+16+(i-NUM_REMAP)*8 and has only control and base. Unmapped offsets read zero.
- R6: An enabled window hits when base <= address < base + ({size field, 16'hFFFF} + 1), with all 36 address bits compared.
- R7: A window whose enable bit is clear never hits, whatever its other fields hold.
- R8: When several enabled windows hit, the lowest-numbered one is reported.
- R9: On a hit in a remappable window the output address is the remap base ORed with (address - base). On a hit in any other window the output equals the input address.
- R10: On a miss the hit flag is 0, and the window index, target and attribute outputs are 0. The output address equals the input address.
- R11: Writing a control value with bit 0 clear also clears that window's base register and, where present, its remap registers.
- R12: A register write changes lookup results only after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Byte offset of the register (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| lk_addr | input | 36 | CPU physical address to decode |
| lk_hit | output | 1 | A window claims lk_addr |
| lk_win | output | $clog2(NUM_WIN) | Index of the winning window |
| lk_target | output | 4 | Target code of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_out_addr | output | 36 | Translated or passed-through address |

## Verification
The lookup is probed at the first and last byte of a window, and one byte beyond each end. This separates a correct half-open range from off-by-one and size-decoding errors. A largest-size 4 GB window placed above the 32-bit line shows whether the top base bits and the 37-bit limit are handled. An address that matches only in its low 32 bits tells a full-width compare from a truncated one. Two overlapping windows, one remappable and one plain, distinguish lowest-index priority from translation and pass-through. Register patterns written with all ones, at both strides and in the reserved hole, expose the field masks and the irregular offset map.

// File: rtl/addr_win_decoder.sv
module addr_win_decoder #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 12,
  localparam int IDX_W    = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [35:0]       lk_addr,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_win,
  output logic [3:0]        lk_target,
  output logic [7:0]        lk_attr,
  output logic [35:0]       lk_out_addr
);

  localparam int HI_BASE = NUM_REMAP * 16 + 16;

  logic              rd_sel  [NUM_WIN];
  logic [31:0]       rd_val  [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;
  logic [35:0]       win_out [NUM_WIN];
  logic [3:0]        win_tgt [NUM_WIN];
  logic [7:0]        win_attr[NUM_WIN];

  logic aligned;
  logic unused_wd;
  assign aligned   = reg_addr[1:0] == 2'b00;
  assign unused_wd = ^{reg_wdata[14:4], reg_wdata[3:1]};

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam bit RMP = i < NUM_REMAP;
    localparam int OFF = RMP ? i * 16 : HI_BASE + (i - NUM_REMAP) * 8;

    logic        en_q;
    logic [3:0]  tgt_q;
    logic [7:0]  attr_q;
    logic [15:0] sz_q;
    logic [15:0] blo_q;
    logic [3:0]  bhi_q;
    logic [15:0] rlo;
    logic [3:0]  rhi;
    logic        here;
    logic [1:0]  word;
    logic        we_ctrl, we_base;

    if (RMP) begin : g_dec
      assign here = aligned && reg_addr[REG_AW-1:4] == (REG_AW-4)'(OFF >> 4);
      assign word = reg_addr[3:2];
    end else begin : g_dec
      assign here = aligned && reg_addr[REG_AW-1:3] == (REG_AW-3)'(OFF >> 3);
      assign word = {1'b0, reg_addr[2]};
    end

    assign we_ctrl = reg_we && here && word == 2'd0;
    assign we_base = reg_we && here && word == 2'd1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        tgt_q  <= '0;
        attr_q <= '0;
        sz_q   <= '0;
        blo_q  <= '0;
        bhi_q  <= '0;
      end else if (we_ctrl) begin
        en_q   <= reg_wdata[0];
        tgt_q  <= reg_wdata[7:4];
        attr_q <= reg_wdata[15:8];
        sz_q   <= reg_wdata[31:16];
        if (!reg_wdata[0]) begin
          blo_q <= '0;
          bhi_q <= '0;
        end
      end else if (we_base) begin
        blo_q <= reg_wdata[31:16];
        bhi_q <= reg_wdata[3:0];
      end
    end

    if (RMP) begin : g_rmp
      logic [15:0] rlo_q;
      logic [3:0]  rhi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else if (we_ctrl && !reg_wdata[0]) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else if (reg_we && here && word == 2'd2) begin
          rlo_q <= reg_wdata[31:16];
        end else if (reg_we && here && word == 2'd3) begin
          rhi_q <= reg_wdata[3:0];
        end
      end
      assign rlo = rlo_q;
      assign rhi = rhi_q;
    end else begin : g_rmp
      assign rlo = '0;
      assign rhi = '0;
    end

    always_comb begin
      case (word)
        2'd0:    rd_val[i] = {sz_q, attr_q, tgt_q, 3'b000, en_q};
        2'd1:    rd_val[i] = {blo_q, 12'h000, bhi_q};
        2'd2:    rd_val[i] = {rlo, 16'h0000};
        default: rd_val[i] = {28'h0, rhi};
      endcase
    end
    assign rd_sel[i] = here;

    logic [35:0] base;
    logic [36:0] lim;
    logic [35:0] offs;
    assign base = {bhi_q, blo_q, 16'h0000};
    assign lim  = {1'b0, base} + {5'b0, sz_q, 16'hFFFF} + 37'd1;
    assign offs = lk_addr - base;

    assign win_hit[i]  = en_q && lk_addr >= base && {1'b0, lk_addr} < lim;
    assign win_out[i]  = RMP ? ({rhi, rlo, 16'h0000} | offs) : lk_addr;
    assign win_tgt[i]  = tgt_q;
    assign win_attr[i] = attr_q;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (rd_sel[i]) reg_rdata = rd_val[i];
  end

  always_comb begin
    lk_hit      = 1'b0;
    lk_win      = '0;
    lk_target   = '0;
    lk_attr     = '0;
    lk_out_addr = lk_addr;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        lk_hit      = 1'b1;
        lk_win      = IDX_W'(i);
        lk_target   = win_tgt[i];
        lk_attr     = win_attr[i];
        lk_out_addr = win_out[i];
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !lk_hit);

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == 4'h0 && lk_attr == 8'h00 && lk_out_addr == lk_addr));

  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && int'(lk_win) >= NUM_REMAP) |-> lk_out_addr == lk_addr);

  // R9
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_out_addr[15:0] == lk_addr[15:0]);

  // R8
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> int'(lk_win) < NUM_WIN);

endmodule

// File: tb/addr_win_decoder_test.sv
module addr_win_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [35:0] lk_addr = '0;
  logic        lk_hit;
  logic [4:0]  lk_win;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic [35:0] lk_out_addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  addr_win_decoder uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_win(lk_win), .lk_target(lk_target),
    .lk_attr(lk_attr), .lk_out_addr(lk_out_addr)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%03h got %08h expected %08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_lk(input logic [35:0] a, input logic eh, input logic [4:0] ew,
                        input logic [3:0] et, input logic [7:0] ea,
                        input logic [35:0] eo, input string tag);
    lk_addr = a;
    #1;
    checks++;
    if (lk_hit !== eh || lk_win !== ew || lk_target !== et || lk_attr !== ea ||
        lk_out_addr !== eo) begin
      errors++;
      $display("FAIL %s lookup %09h got hit=%0b win=%0d tgt=%h attr=%h out=%09h expected hit=%0b win=%0d tgt=%h attr=%h out=%09h",
               tag, a, lk_hit, lk_win, lk_target, lk_attr, lk_out_addr, eh, ew, et, ea, eo);
    end
  endtask

  task automatic t_reset;
    chk_rd(12'h000, 32'h0, "R1");
    chk_rd(12'h024, 32'h0, "R1");
    chk_rd(12'h090, 32'h0, "R1");
    chk_lk(36'h0_0000_0000, 0, 0, 0, 0, 36'h0_0000_0000, "R1");
  endtask

  task automatic t_layout;
    wr(12'h030, 32'h0003_A57F);
    chk_rd(12'h030, 32'h0003_A571, "R2");
    wr(12'h034, 32'hFFFF_FFFF);
    chk_rd(12'h034, 32'hFFFF_000F, "R3");
    wr(12'h038, 32'hFFFF_FFFF);
    chk_rd(12'h038, 32'hFFFF_0000, "R4");
    wr(12'h03C, 32'hFFFF_FFFF);
    chk_rd(12'h03C, 32'h0000_000F, "R4");
    wr(12'h030, 32'h0);
    chk_rd(12'h034, 32'h0, "R11");
    chk_rd(12'h038, 32'h0, "R11");
    chk_rd(12'h03C, 32'h0, "R11");
  endtask

  task automatic t_offsets;
    wr(12'h090, 32'h0000_AA60);
    chk_rd(12'h090, 32'h0000_AA60, "R5");
    wr(12'h094, 32'h1234_5678);
    chk_rd(12'h094, 32'h1234_0008, "R5");
    wr(12'h098, 32'h0000_0010);
    chk_rd(12'h098, 32'h0000_0010, "R5");
    chk_rd(12'h090, 32'h0000_AA60, "R5");
    wr(12'h0E8, 32'h0000_0070);
    chk_rd(12'h0E8, 32'h0000_0070, "R5");
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h084, 32'hFFFF_FFFF);
    chk_rd(12'h080, 32'h0, "R5");
    chk_rd(12'h084, 32'h0, "R5");
    chk_rd(12'h0F0, 32'h0, "R5");
    chk_rd(12'h070, 32'h0, "R5");
    wr(12'h090, 32'h0);
    wr(12'h098, 32'h0);
    wr(12'h0E8, 32'h0);
  endtask

  task automatic t_match;
    wr(12'h024, 32'h2000_0001);
    wr(12'h028, 32'h4000_0000);
    wr(12'h02C, 32'h0000_0002);
    wr(12'h020, 32'h000F_1D51);
    chk_lk(36'h1_2000_0000, 1, 2, 4'h5, 8'h1D, 36'h2_4000_0000, "R6 first byte");
    chk_lk(36'h1_200F_FFFF, 1, 2, 4'h5, 8'h1D, 36'h2_400F_FFFF, "R9 last byte");
    chk_lk(36'h1_2010_0000, 0, 0, 0, 0, 36'h1_2010_0000, "R6 past end");
    chk_lk(36'h1_1FFF_FFFF, 0, 0, 0, 0, 36'h1_1FFF_FFFF, "R6 below base");
    chk_lk(36'h0_2000_0000, 0, 0, 0, 0, 36'h0_2000_0000, "R6 high bits");
    wr(12'h020, 32'h000F_1D50);
    chk_rd(12'h024, 32'h0, "R11");
    chk_rd(12'h028, 32'h0, "R11");
    chk_rd(12'h02C, 32'h0, "R11");
    chk_lk(36'h0_0000_0100, 0, 0, 0, 0, 36'h0_0000_0100, "R7");
    wr(12'h020, 32'h0);
  endtask

  task automatic t_big;
    wr(12'h004, 32'h0000_0001);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h000; reg_wdata = 32'hFFFF_0231;
    chk_lk(36'h1_8000_0000, 0, 0, 0, 0, 36'h1_8000_0000, "R12 before edge");
    @(negedge clk);
    reg_we = 1'b0;
    chk_lk(36'h1_8000_0000, 1, 0, 4'h3, 8'h02, 36'h0_8000_0000, "R12 after edge");
    chk_lk(36'h1_FFFF_FFFF, 1, 0, 4'h3, 8'h02, 36'h0_FFFF_FFFF, "R6 4GB top");
    chk_lk(36'h2_0000_0000, 0, 0, 0, 0, 36'h2_0000_0000, "R6 4GB end");
    chk_lk(36'h1_0000_0000, 1, 0, 4'h3, 8'h02, 36'h0_0000_0000, "R9 4GB base");
    wr(12'h000, 32'h0);
    chk_lk(36'h1_0000_0000, 0, 0, 0, 0, 36'h1_0000_0000, "R10");
  endtask

  task automatic t_priority;
    wr(12'h0A4, 32'h8000_0000);
    wr(12'h0A0, 32'h0000_E041);
    chk_lk(36'h0_8000_1234, 1, 10, 4'h4, 8'hE0, 36'h0_8000_1234, "R9 passthru");
    chk_lk(36'h0_8001_0000, 0, 0, 0, 0, 36'h0_8001_0000, "R6 64KB end");
    wr(12'h054, 32'h8000_0000);
    wr(12'h058, 32'h0000_0000);
    wr(12'h05C, 32'h0000_0009);
    wr(12'h050, 32'h0001_0131);
    chk_lk(36'h0_8000_1234, 1, 5, 4'h3, 8'h01, 36'h9_0000_1234, "R8");
    chk_lk(36'h0_8001_0004, 1, 5, 4'h3, 8'h01, 36'h9_0001_0004, "R9");
    wr(12'h050, 32'h0);
    chk_lk(36'h0_8000_1234, 1, 10, 4'h4, 8'hE0, 36'h0_8000_1234, "R7");
    chk_rd(12'h05C, 32'h0, "R11");
    wr(12'h0A0, 32'h0);
    chk_lk(36'h0_8000_1234, 0, 0, 0, 0, 36'h0_8000_1234, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_layout;
    t_offsets;
    t_match;
    t_big;
    t_priority;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule